// File: doc/BRIEF.md
# Six-Direction Orientation Interrupt Unit

This block watches a stream of signed three-axis acceleration samples and decides, at every sample, whether the device is lying along one of the six axis directions (+X, -X, +Y, -Y, +Z, -Z) or sits in an unknown orientation. Each sample arrives with a one-cycle `smp_vld` strobe at the output data rate. Every axis is tested against a 7-bit unsigned threshold in both directions. The resulting six event flags drive the zone decision.

Two interrupt modes are offered. In movement mode the interrupt fires for one sample period when the orientation leaves the unknown zone and enters any known zone. In direction mode the interrupt stays high for as long as the orientation is inside a known zone. The event flags and an interrupt-active flag are kept in an 8-bit source register. Reading that register clears the interrupt. In latched operation the register holds its contents after an interrupt until it is read.

Top module: `orient6d_irq`

## Requirements
- R1: An axis raises its high event when its sample is non-negative and the upper 7 bits of its 8-bit magnitude are strictly greater than `thr`. It raises its low event when the sample is negative and the same magnitude bits are strictly greater than `thr`. The magnitude of -128 is 128.
- R2: `src_q` bit 7 is always 0 and bit 6 is the interrupt-active flag. Bits 5 to 0 are the +Z, -Z, +Y, -Y, +X and -X events, in that order.
- R3: While `rst_n` is low, `src_q` and `irq` are 0, and the orientation history is the unknown zone.
- R4: The orientation is in a known zone only when exactly one of the six events is active. No event, or two or more events, counts as the unknown zone.
- R5: With `mode` = 01, a sample whose zone is known while the previous sample's zone was unknown sets the interrupt. The interrupt stays high until the next strobe. That strobe clears it unless it fires again.
- R6: With `mode` = 11, every sample in a known zone sets the interrupt and every sample in the unknown zone clears it.
- R7: With `mode` = 00 or 10, no interrupt is raised. The event bits still follow the comparisons.
- R8: With `latch_en` = 0, every strobe reloads the event bits and the interrupt-active flag from the current sample.
- R9: With `latch_en` = 1, once the interrupt-active flag is set, strobes leave `src_q` unchanged until a read. A strobe that comes in the same cycle as a read loads the new sample.
- R10: A `src_rd` pulse without a strobe clears the interrupt-active flag and `irq` on the next edge, and keeps the event bits.
- R11: Without a strobe or a read, `src_q` and `irq` hold their values whatever the sample, threshold and mode inputs do.
- R12: `irq` always equals `src_q` bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe marking a new sample |
| acc_x | input | 8 | Signed X sample |
| acc_y | input | 8 | Signed Y sample |
| acc_z | input | 8 | Signed Z sample |
| thr | input | 7 | Unsigned threshold |
| mode | input | 2 | 01 movement, 11 direction, 00/10 off |
| latch_en | input | 1 | Hold the source register after an interrupt until read |
| src_rd | input | 1 | Read strobe of the source register |
| src_q | output | 8 | Source register |
| irq | output | 1 | Interrupt output |

## Verification
A stale orientation history shows up as a movement interrupt that is missing or repeated, and it appears at the very next strobe that enters a known zone. A comparator or magnitude fault flips an event bit in `src_q` one clock after the strobe that carries the boundary sample. A freeze or read-clear fault shows at the next strobe or the next read. Each of these faults stays visible until some later strobe overwrites it.

// File: rtl/orient_pkg.sv
package orient_pkg;
   localparam int NUM_AXES = 3;
   localparam int NUM_EV   = 2 * NUM_AXES;
   localparam int SRC_W    = 8;

   typedef enum logic [1:0] {
      MD_OFF_A = 2'b00,
      MD_MOVE  = 2'b01,
      MD_OFF_B = 2'b10,
      MD_DIR   = 2'b11
   } mode_e;
endpackage

// File: rtl/orient_axis_cmp.sv
module orient_axis_cmp #(
   parameter int SW = 8,
   parameter int TW = 7
) (
   input  logic [SW-1:0] smp,
   input  logic [TW-1:0] thr,
   output logic          hi,
   output logic          lo
);
   localparam int MAG_LSB = SW - TW;

   logic [SW-1:0] mag;
   logic          over;

   generate
      if (TW >= SW) begin : g_bad_width
         $error("threshold width must be below sample width");
      end
   endgenerate

   always_comb begin
      mag  = smp[SW-1] ? (~smp + 1'b1) : smp;
      over = mag[SW-1:MAG_LSB] > thr;
      hi   = !smp[SW-1] && over;
      lo   =  smp[SW-1] && over;
   end

   // R1: one axis never reports both directions
   always_comb begin
      if (!$isunknown({hi, lo}))
         a_r1_dir_exclusive: assert (!(hi && lo));
   end
endmodule

// File: rtl/orient_zone_dec.sv
module orient_zone_dec
   import orient_pkg::*;
#(
   parameter int NEV = NUM_EV
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_vld,
   input  logic [NEV-1:0] ev,
   input  mode_e          mode,
   output logic           known,
   output logic           fire
);
   logic prev_known_q;

   always_comb begin
      known = (ev != '0) && ((ev & (ev - 1'b1)) == '0);
      case (mode)
         MD_MOVE: fire = known && !prev_known_q;
         MD_DIR:  fire = known;
         default: fire = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_known_q <= 1'b0;
      else if (smp_vld) prev_known_q <= known;
   end

   // R7: the off modes never request an interrupt
   a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_OFF_A || mode == MD_OFF_B) |-> !fire);
   // R5: after a firing strobe the history reads known
   a_r5_history_known: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && fire) |=> prev_known_q);
endmodule

// File: rtl/orient_src_reg.sv
module orient_src_reg #(
   parameter int NEV       = 6,
   parameter bit HAS_LATCH = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           smp_vld,
   input  logic           latch_en,
   input  logic           src_rd,
   input  logic           fire,
   input  logic [NEV-1:0] ev_now,
   output logic           ia_q,
   output logic [NEV-1:0] ev_q
);
   logic load;

   generate
      if (HAS_LATCH) begin : g_latch
         assign load = smp_vld && (!latch_en || !ia_q || src_rd);
      end else begin : g_plain
         logic unused_latch;
         assign unused_latch = latch_en;
         assign load = smp_vld;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ia_q <= 1'b0;
         ev_q <= '0;
      end else if (load) begin
         ia_q <= fire;
         ev_q <= ev_now;
      end else if (src_rd) begin
         ia_q <= 1'b0;
      end
   end

   // R11: nothing moves without a strobe or read
   a_r11_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_vld && !src_rd) |=> ($stable(ia_q) && $stable(ev_q)));
   // R10: a read without a strobe clears the flag, keeps events
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rd && !smp_vld) |=> (!ia_q && $stable(ev_q)));
   // R9: a latched register is frozen until read
   a_r9_latched_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_LATCH && latch_en && ia_q && !src_rd) |=> ($stable(ia_q) && $stable(ev_q)));
   // R8: unlatched strobes reload the events
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && !latch_en) |=> (ev_q == $past(ev_now)));
endmodule

// File: rtl/orient6d_irq.sv
module orient6d_irq
   import orient_pkg::*;
#(
   parameter int SW        = 8,
   parameter int TW        = 7,
   parameter bit HAS_LATCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [SW-1:0] acc_x,
   input  logic [SW-1:0] acc_y,
   input  logic [SW-1:0] acc_z,
   input  logic [TW-1:0] thr,
   input  logic [1:0]    mode,
   input  logic          latch_en,
   input  logic          src_rd,
   output logic [7:0]    src_q,
   output logic          irq
);
   localparam int PAD_W = SRC_W - NUM_EV - 1;

   logic [SW-1:0]     smp [NUM_AXES];
   logic [NUM_EV-1:0] ev_now;
   logic [NUM_EV-1:0] ev_q;
   logic              known;
   logic              fire;
   logic              ia_q;
   mode_e             mode_v;

   assign smp[0] = acc_x;
   assign smp[1] = acc_y;
   assign smp[2] = acc_z;
   assign mode_v = mode_e'(mode);

   generate
      if (PAD_W < 1) begin : g_bad_src
         $error("source register too narrow");
      end
      for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
         orient_axis_cmp #(.SW(SW), .TW(TW)) u_cmp (
            .smp (smp[a]),
            .thr (thr),
            .hi  (ev_now[2*a+1]),
            .lo  (ev_now[2*a])
         );
      end
   endgenerate

   orient_zone_dec #(.NEV(NUM_EV)) u_zone (
      .clk     (clk),
      .rst_n   (rst_n),
      .smp_vld (smp_vld),
      .ev      (ev_now),
      .mode    (mode_v),
      .known   (known),
      .fire    (fire)
   );

   orient_src_reg #(.NEV(NUM_EV), .HAS_LATCH(HAS_LATCH)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_vld  (smp_vld),
      .latch_en (latch_en),
      .src_rd   (src_rd),
      .fire     (fire),
      .ev_now   (ev_now),
      .ia_q     (ia_q),
      .ev_q     (ev_q)
   );

   assign src_q = {{PAD_W{1'b0}}, ia_q, ev_q};
   assign irq   = ia_q;

   // R5: an unlatched movement pulse ends at the next strobe
   a_r5_single_period: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en && mode_v == MD_MOVE && smp_vld && ia_q && !src_rd) |=> !irq);
   // R6: direction mode follows the zone at each unlatched strobe
   a_r6_dir_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en && mode_v == MD_DIR && smp_vld) |=> (irq == $past(known)));
   // R3: reset leaves the register clear
   a_r3_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (src_q == 8'h00 && !irq));
endmodule

// File: tb/sim_orient6d_irq.sv
module sim_orient6d_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_vld = 1'b0;
   logic [7:0] acc_x = '0, acc_y = '0, acc_z = '0;
   logic [6:0] thr = '0;
   logic [1:0] mode = 2'b00;
   logic       latch_en = 1'b0;
   logic       src_rd = 1'b0;
   logic [7:0] src_q;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   orient6d_irq u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
      .thr(thr), .mode(mode), .latch_en(latch_en),
      .src_rd(src_rd), .src_q(src_q), .irq(irq)
   );

   typedef struct packed {
      logic [7:0] x, y, z;
      logic [6:0] th;
      logic [1:0] md;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{8'h00, 8'h00, 8'h00, 7'd0,   2'b01, 8'h00},
      '{8'h28, 8'h00, 8'h00, 7'd10,  2'b01, 8'h42},
      '{8'h28, 8'h00, 8'h00, 7'd10,  2'b01, 8'h02},
      '{8'h00, 8'h00, 8'hD8, 7'd10,  2'b01, 8'h10},
      '{8'h28, 8'hD8, 8'h00, 7'd10,  2'b01, 8'h06},
      '{8'h00, 8'hD8, 8'h00, 7'd10,  2'b01, 8'h44},
      '{8'h00, 8'hD8, 8'h00, 7'd10,  2'b11, 8'h44},
      '{8'h00, 8'h00, 8'h28, 7'd10,  2'b11, 8'h60},
      '{8'h14, 8'h00, 8'h00, 7'd10,  2'b11, 8'h00},
      '{8'h16, 8'h00, 8'h00, 7'd10,  2'b11, 8'h42},
      '{8'hEB, 8'h00, 8'h00, 7'd10,  2'b11, 8'h00},
      '{8'hEA, 8'h00, 8'h00, 7'd10,  2'b11, 8'h41},
      '{8'hEA, 8'h00, 8'h00, 7'd10,  2'b00, 8'h01},
      '{8'h00, 8'h64, 8'h00, 7'd10,  2'b10, 8'h08},
      '{8'h80, 8'h00, 8'h00, 7'd127, 2'b11, 8'h00},
      '{8'h7F, 8'h00, 8'h00, 7'd62,  2'b11, 8'h42},
      '{8'h7F, 8'h00, 8'h00, 7'd63,  2'b11, 8'h00},
      '{8'h80, 8'h00, 8'h00, 7'd63,  2'b01, 8'h41},
      '{8'h00, 8'h00, 8'h00, 7'd0,   2'b01, 8'h00},
      '{8'h01, 8'h00, 8'h00, 7'd0,   2'b01, 8'h00},
      '{8'h02, 8'h00, 8'h00, 7'd0,   2'b01, 8'h42}
   };

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic strobe(input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] z, input logic rd);
      @(negedge clk);
      acc_x = x; acc_y = y; acc_z = z;
      smp_vld = 1'b1; src_rd = rd;
      @(negedge clk);
      smp_vld = 1'b0; src_rd = 1'b0;
   endtask

   task automatic read_src();
      @(negedge clk);
      src_rd = 1'b1;
      @(negedge clk);
      src_rd = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R3 reset src", src_q, 8'h00);
      chk("R3 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;

      // table walk: R1 R2 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         thr  = VEC[i].th;
         mode = VEC[i].md;
         strobe(VEC[i].x, VEC[i].y, VEC[i].z, 1'b0);
         chk($sformatf("R1 R2 R4 R5 R6 R7 R8 vector %0d", i), src_q, VEC[i].exp);
         chk($sformatf("R12 vector %0d", i), {7'd0, irq}, {7'd0, src_q[6]});
      end

      // R11: inputs move without a strobe
      acc_x = 8'h00; acc_y = 8'h7F; thr = 7'd0; mode = 2'b11;
      repeat (4) @(negedge clk);
      chk("R11 hold", src_q, 8'h42);

      // R5: the movement pulse spans the whole sample period
      mode = 2'b01; thr = 7'd10;
      strobe(8'h00, 8'h00, 8'h00, 1'b0);
      strobe(8'h28, 8'h00, 8'h00, 1'b0);
      repeat (5) @(negedge clk);
      chk("R5 pulse held between strobes", {7'd0, irq}, 8'h01);
      strobe(8'h28, 8'h00, 8'h00, 1'b0);
      chk("R5 pulse ends at next strobe", src_q, 8'h02);

      // R10: read clears the flag, keeps the events
      mode = 2'b11;
      strobe(8'h28, 8'h00, 8'h00, 1'b0);
      chk("R6 direction set", src_q, 8'h42);
      read_src();
      chk("R10 read clears", src_q, 8'h02);
      chk("R10 irq low", {7'd0, irq}, 8'h00);

      // R9: latched freeze
      latch_en = 1'b1; mode = 2'b01;
      strobe(8'h00, 8'h00, 8'h00, 1'b0);
      chk("R9 latched unknown", src_q, 8'h00);
      strobe(8'h28, 8'h00, 8'h00, 1'b0);
      chk("R9 latched fire", src_q, 8'h42);
      strobe(8'h00, 8'h00, 8'hD8, 1'b0);
      chk("R9 frozen", src_q, 8'h42);
      read_src();
      chk("R9 R10 read releases", src_q, 8'h02);
      strobe(8'h00, 8'h00, 8'hD8, 1'b0);
      chk("R9 refresh after read", src_q, 8'h10);
      strobe(8'h00, 8'h00, 8'h00, 1'b0);
      strobe(8'h00, 8'h28, 8'h00, 1'b0);
      chk("R9 latched second fire", src_q, 8'h48);
      strobe(8'h28, 8'h00, 8'h00, 1'b1);
      chk("R9 read with strobe loads", src_q, 8'h02);

      // R3: reset in the middle of operation
      mode = 2'b11;
      strobe(8'h28, 8'h00, 8'h00, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R3 mid reset", src_q, 8'h00);
      rst_n = 1'b1;
      latch_en = 1'b0; mode = 2'b01;
      strobe(8'h28, 8'h00, 8'h00, 1'b0);
      chk("R3 history unknown after reset", src_q, 8'h42);

      finish_run();
   end
endmodule